// File: doc/BRIEF.md
# Two-Round Challenge-Response Authenticator

This block runs the device side of a two-stage challenge-response handshake for a secure memory. It holds three 64-bit values: a secret seed, a rolling cryptogram and a session key. The host sends a random value together with a challenge. The block runs a keyed mixing function over its seed, its cryptogram and the host random, and compares the result with the challenge. On a match it rolls the cryptogram forward and derives a fresh session key. The host can then read the new cryptogram and check it against its own prediction.

A second round uses the session key in place of the seed. It gates entry to an encrypted mode. Every failed comparison bumps a failure counter. Once the counter passes its limit the block locks and answers every later command with an error at once.

The mixing function is a placeholder that is easy to replace, not a real cipher. It takes several cycles and runs in a small engine behind a start/done handshake. Host bus decoding and non-volatile storage sit outside this block. A provisioning strobe loads the seed and the starting cryptogram.

Top module: `auth_handshake`

## Requirements
- R1: After reset, busy, rsp_valid, auth_mode, enc_mode, locked and fail_count are all 0, and crypt_out is 0.
- R2: When the block is idle and not locked, a prov_valid pulse with no cmd_valid in the same cycle loads prov_seed as the seed and prov_crypt as the cryptogram, clears the session key and clears both mode flags. A prov_valid pulse while busy or locked changes nothing.
- R3: The mixing function F(k,a,b) works as follows. Set s = a xor b. Then, for r = 0 to 7, set s = rotl13(s xor k) + (k xor r), where r is zero-extended to 64 bits. The result is the final s. An authenticate command (cmd_op = 0) computes C1 = F(seed, cryptogram, cmd_q0). If C1 equals cmd_q1, the block answers with rsp_ok, sets auth_mode and clears enc_mode.
- R4: On a successful authentication, the cryptogram becomes F(seed, C1, 0) and the session key becomes C1 xor seed. The host's own prediction F(seed, cmd_q1, 0) therefore equals crypt_out.
- R5: An encrypt command (cmd_op = 1) with auth_mode set computes E = F(session key, cryptogram, cmd_q0). If E equals cmd_q1, the block answers with rsp_ok and sets enc_mode. enc_mode is never set without auth_mode.
- R6: An encrypt command while auth_mode is clear gets rsp_err at once. It does not run the engine, and fail_count, the flags and crypt_out stay unchanged.
- R7: A failed comparison in either round answers with rsp_err. It leaves the cryptogram and the session key unchanged, clears both mode flags and raises fail_count by exactly 1.
- R8: The block locks on the failure that takes fail_count above 8, which is the ninth failure. From then on, locked stays 1 until reset, both flags stay clear, busy stays 0, and every command gets rsp_err in the following cycle without computing.
- R9: While busy is 1, cmd_valid and prov_valid are ignored. Each accepted command produces exactly one response.
- R10: rsp_valid is a one-cycle pulse per response, with exactly one of rsp_ok and rsp_err set while it is high. Both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prov_valid | input | 1 | Load seed and cryptogram |
| prov_seed | input | 64 | Secret seed to load |
| prov_crypt | input | 64 | Starting cryptogram to load |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = authenticate, 1 = encrypt round |
| cmd_q0 | input | 64 | Host random value |
| cmd_q1 | input | 64 | Host challenge |
| busy | output | 1 | A command is in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Response: success |
| rsp_err | output | 1 | Response: failure or refused |
| crypt_out | output | 64 | Current cryptogram |
| auth_mode | output | 1 | Authenticated flag |
| enc_mode | output | 1 | Encrypted-mode flag |
| fail_count | output | 4 | Failure counter (saturates at 9) |
| locked | output | 1 | Lockout state |

## Verification
The properties assume that reset is held for at least one clock edge, that command and provisioning operands are known values whenever their strobes are high, and that a change of crypt_out is only ever caused by the block's own work or a provisioning load. The stimulus drives every strobe as a single-cycle pulse between clock edges, with fully defined operands. It issues overlapping commands and provisioning only in the tests that probe the busy and locked refusal paths. Challenges are built from a separate model of the mixing function, so that both matching and deliberately wrong values reach the comparators in each round.

// File: rtl/auth_pkg.sv
package auth_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COMPUTE1  = 3'd1,
        ST_COMPARE   = 3'd2,
        ST_COMPUTE2  = 3'd3,
        ST_AUTH_OK   = 3'd4,
        ST_ENC_ROUND = 3'd5,
        ST_ENC_OK    = 3'd6,
        ST_LOCKED    = 3'd7
    } auth_state_e;

    localparam logic OP_AUTH = 1'b0;
    localparam logic OP_ENC  = 1'b1;

endpackage

// File: rtl/mix_engine.sv
module mix_engine #(
    parameter int W      = 64,
    parameter int ROUNDS = 8,
    parameter int ROT    = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] key,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

    typedef struct packed {
        logic [W-1:0]  s;
        logic [W-1:0]  k;
        logic [CW-1:0] cnt;
        logic          run;
        logic          done;
    } eng_t;

    eng_t q, d;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x);
        return (x << ROT) | (x >> (W - ROT));
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.run) begin
            d.s = rotl(q.s ^ q.k) + (q.k ^ W'(q.cnt));
            if (q.cnt == LAST) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (start) begin
            d.s   = op_a ^ op_b;
            d.k   = key;
            d.cnt = '0;
            d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.run;
    assign done   = q.done;
    assign result = q.s;
endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
    parameter int MAX_FAIL = 8,
    localparam int FCW = $clog2(MAX_FAIL + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bump,
    output logic [FCW-1:0] count,
    output logic           locked
);
    logic [FCW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (bump && (cnt_q <= FCW'(MAX_FAIL))) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count  = cnt_q;
    assign locked = (cnt_q > FCW'(MAX_FAIL));
endmodule

// File: rtl/auth_handshake.sv
module auth_handshake
    import auth_pkg::*;
#(
    parameter int W        = 64,
    parameter int ROUNDS   = 8,
    parameter int ROT      = 13,
    parameter int MAX_FAIL = 8,
    localparam int FCW = $clog2(MAX_FAIL + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prov_valid,
    input  logic [W-1:0]   prov_seed,
    input  logic [W-1:0]   prov_crypt,
    input  logic           cmd_valid,
    input  logic           cmd_op,
    input  logic [W-1:0]   cmd_q0,
    input  logic [W-1:0]   cmd_q1,
    output logic           busy,
    output logic           rsp_valid,
    output logic           rsp_ok,
    output logic           rsp_err,
    output logic [W-1:0]   crypt_out,
    output logic           auth_mode,
    output logic           enc_mode,
    output logic [FCW-1:0] fail_count,
    output logic           locked
);
    typedef struct packed {
        auth_state_e  st;
        logic [W-1:0] gc;
        logic [W-1:0] ci;
        logic [W-1:0] sk;
        logic [W-1:0] q1;
        logic [W-1:0] calc;
        logic         auth;
        logic         enc;
        logic         rsp_v;
        logic         rsp_ok;
        logic         rsp_err;
    } core_t;

    core_t q, d;

    logic         eng_start, eng_busy, eng_done;
    logic [W-1:0] eng_key, eng_a, eng_b, eng_res;
    logic         bump, lock_now;

    mix_engine #(.W(W), .ROUNDS(ROUNDS), .ROT(ROT)) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .key    (eng_key),
        .op_a   (eng_a),
        .op_b   (eng_b),
        .busy   (eng_busy),
        .done   (eng_done),
        .result (eng_res)
    );

    fail_counter #(.MAX_FAIL(MAX_FAIL)) u_fail (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (bump),
        .count  (fail_count),
        .locked (lock_now)
    );

    always_comb begin
        logic fail;
        d         = q;
        d.rsp_v   = 1'b0;
        d.rsp_ok  = 1'b0;
        d.rsp_err = 1'b0;
        eng_start = 1'b0;
        eng_key   = q.gc;
        eng_a     = q.ci;
        eng_b     = '0;
        fail      = 1'b0;
        bump      = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_op == OP_ENC) begin
                        if (!q.auth) begin
                            d.rsp_v   = 1'b1;
                            d.rsp_err = 1'b1;
                        end else begin
                            eng_start = 1'b1;
                            eng_key   = q.sk;
                            eng_b     = cmd_q0;
                            d.q1      = cmd_q1;
                            d.st      = ST_ENC_ROUND;
                        end
                    end else begin
                        eng_start = 1'b1;
                        eng_b     = cmd_q0;
                        d.q1      = cmd_q1;
                        d.st      = ST_COMPUTE1;
                    end
                end else if (prov_valid) begin
                    d.gc   = prov_seed;
                    d.ci   = prov_crypt;
                    d.sk   = '0;
                    d.auth = 1'b0;
                    d.enc  = 1'b0;
                end
            end
            ST_COMPUTE1: begin
                if (eng_done) begin
                    d.calc = eng_res;
                    d.st   = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (q.calc == q.q1) begin
                    eng_start = 1'b1;
                    eng_a     = q.calc;
                    d.st      = ST_COMPUTE2;
                end else begin
                    fail = 1'b1;
                end
            end
            ST_COMPUTE2: begin
                if (eng_done) begin
                    d.ci   = eng_res;
                    d.sk   = q.calc ^ q.gc;
                    d.auth = 1'b1;
                    d.enc  = 1'b0;
                    d.st   = ST_AUTH_OK;
                end
            end
            ST_AUTH_OK: begin
                d.rsp_v  = 1'b1;
                d.rsp_ok = 1'b1;
                d.st     = ST_IDLE;
            end
            ST_ENC_ROUND: begin
                if (eng_done) begin
                    if (eng_res == q.q1) begin
                        d.enc = 1'b1;
                        d.st  = ST_ENC_OK;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            ST_ENC_OK: begin
                d.rsp_v  = 1'b1;
                d.rsp_ok = 1'b1;
                d.st     = ST_IDLE;
            end
            ST_LOCKED: begin
                if (cmd_valid) begin
                    d.rsp_v   = 1'b1;
                    d.rsp_err = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (fail) begin
            bump      = 1'b1;
            d.auth    = 1'b0;
            d.enc     = 1'b0;
            d.rsp_v   = 1'b1;
            d.rsp_err = 1'b1;
            d.st      = (fail_count >= FCW'(MAX_FAIL)) ? ST_LOCKED : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE) && (q.st != ST_LOCKED);
    assign rsp_valid = q.rsp_v;
    assign rsp_ok    = q.rsp_ok;
    assign rsp_err   = q.rsp_err;
    assign crypt_out = q.ci;
    assign auth_mode = q.auth;
    assign enc_mode  = q.enc;
    assign locked    = lock_now;
endmodule

// File: rtl/auth_handshake_chk.sv
module auth_handshake_chk #(
    parameter int W        = 64,
    parameter int MAX_FAIL = 8,
    localparam int FCW = $clog2(MAX_FAIL + 2)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           prov_valid,
    input logic           busy,
    input logic           rsp_valid,
    input logic           rsp_ok,
    input logic           rsp_err,
    input logic [W-1:0]   crypt_out,
    input logic           auth_mode,
    input logic           enc_mode,
    input logic [FCW-1:0] fail_count,
    input logic           locked
);
    AST_RSP_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok != rsp_err)); // R10
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_ok && !rsp_err)); // R10
    AST_AUTH_RISE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auth_mode) |=> (rsp_valid && rsp_ok)); // R3
    AST_ENC_RISE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_mode) |=> (rsp_valid && rsp_ok)); // R5
    AST_ENC_NEEDS_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        enc_mode |-> auth_mode); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count == $past(fail_count)) || (fail_count == $past(fail_count) + 1'b1)); // R7
    AST_COUNT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count != $past(fail_count)) |-> (rsp_valid && rsp_err)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R8
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!busy && !auth_mode && !enc_mode)); // R8
    AST_CRYPT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (crypt_out != $past(crypt_out)) |-> ($past(busy) || $past(prov_valid))); // R2
endmodule

bind auth_handshake auth_handshake_chk #(.W(W), .MAX_FAIL(MAX_FAIL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prov_valid (prov_valid),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_err    (rsp_err),
    .crypt_out  (crypt_out),
    .auth_mode  (auth_mode),
    .enc_mode   (enc_mode),
    .fail_count (fail_count),
    .locked     (locked)
);

// File: tb/sim_auth_handshake.sv
module sim_auth_handshake;
    localparam time HALF = 2ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prov_valid = 1'b0;
    logic [63:0] prov_seed = '0, prov_crypt = '0;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [63:0] cmd_q0 = '0, cmd_q1 = '0;
    logic        busy, rsp_valid, rsp_ok, rsp_err, auth_mode, enc_mode, locked;
    logic [63:0] crypt_out;
    logic [3:0]  fail_count;

    always #HALF clk = ~clk;

    auth_handshake u0 (.*);

    int n_chk = 0, n_fail = 0;

    // independent model state
    logic [63:0] m_gc, m_ci, m_sk;
    logic        m_auth, m_enc;
    int          m_cnt;

    typedef struct packed {
        logic        op;
        logic [63:0] q0;
        logic        good;
        logic        exp_ok;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1},
        '{1'b1, 64'hFEED_FACE_CAFE_BEEF, 1'b1, 1'b1},
        '{1'b0, 64'h1111_2222_3333_4444, 1'b0, 1'b0},
        '{1'b1, 64'h5555_6666_7777_8888, 1'b1, 1'b0},
        '{1'b0, 64'hA5A5_5A5A_0F0F_F0F0, 1'b1, 1'b1},
        '{1'b1, 64'h0000_0000_0000_0001, 1'b0, 1'b0},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1},
        '{1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b1}
    };

    function automatic logic [63:0] f2(input logic [63:0] k, a, b);
        logic [63:0] s, t;
        s = a ^ b;
        for (int r = 0; r < 8; r++) begin
            t = s ^ k;
            s = {t[50:0], t[63:51]} + (k ^ 64'(r));
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic op, input logic [63:0] q0, input logic [63:0] q1,
                           output logic ok, output logic err);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_q0 = q0; cmd_q1 = q1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
        ok = rsp_ok; err = rsp_err;
    endtask

    task automatic check_state(input string req);
        check({req, " crypt_out"}, crypt_out, m_ci);
        check({req, " auth_mode"}, 64'(auth_mode), 64'(m_auth));
        check({req, " enc_mode"}, 64'(enc_mode), 64'(m_enc));
        check({req, " fail_count"}, 64'(fail_count), 64'(m_cnt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ok, err, exp_ok;
        logic [63:0] c1, q1, e;
        int rsp_seen;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 0);
        check("R1 rsp_valid", 64'(rsp_valid), 0);
        check("R1 locked", 64'(locked), 0);
        check("R1 crypt_out", crypt_out, 0);
        check("R1 flags", 64'({auth_mode, enc_mode}), 0);
        check("R1 fail_count", 64'(fail_count), 0);

        // R2 provisioning
        m_gc = 64'h3C3C_1234_DEAD_0042; m_ci = 64'h0BAD_F00D_7777_1357; m_sk = '0;
        m_auth = 0; m_enc = 0; m_cnt = 0;
        prov_valid = 1'b1; prov_seed = m_gc; prov_crypt = m_ci;
        @(negedge clk);
        prov_valid = 1'b0;
        check("R2 load crypt_out", crypt_out, m_ci);

        // table walk: R3 R4 R5 R6 R7 R10
        foreach (VECS[i]) begin
            exp_ok = VECS[i].exp_ok;
            if (VECS[i].op == 1'b0) begin
                c1 = f2(m_gc, m_ci, VECS[i].q0);
                q1 = VECS[i].good ? c1 : (c1 ^ 64'h1);
                run_cmd(1'b0, VECS[i].q0, q1, ok, err);
                if (VECS[i].good) begin
                    m_ci = f2(m_gc, c1, 64'h0); m_sk = c1 ^ m_gc; m_auth = 1; m_enc = 0;
                    check("R4 host Q2 prediction", crypt_out, f2(m_gc, q1, 64'h0));
                end else begin
                    m_cnt++; m_auth = 0; m_enc = 0;
                end
            end else begin
                if (!m_auth) begin
                    q1 = 64'h0;
                    run_cmd(1'b1, VECS[i].q0, q1, ok, err);
                end else begin
                    e  = f2(m_sk, m_ci, VECS[i].q0);
                    q1 = VECS[i].good ? e : ~e;
                    run_cmd(1'b1, VECS[i].q0, q1, ok, err);
                    if (VECS[i].good) m_enc = 1;
                    else begin m_cnt++; m_auth = 0; m_enc = 0; end
                end
            end
            check($sformatf("R3/R5/R6/R7 vec%0d rsp_ok", i), 64'(ok), 64'(exp_ok));
            check($sformatf("R10 vec%0d rsp_err", i), 64'(err), 64'(!exp_ok));
            check_state($sformatf("R3/R5/R6/R7 vec%0d", i));
        end

        // R9: commands and provisioning during busy are ignored
        c1 = f2(m_gc, m_ci, 64'h2468_ACE0_1357_9BDF);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_q0 = 64'h2468_ACE0_1357_9BDF; cmd_q1 = c1;
        @(negedge clk);
        check("R9 busy after accept", 64'(busy), 1);
        cmd_op = 1'b1; cmd_q0 = 64'h9; cmd_q1 = 64'h9;
        prov_valid = 1'b1; prov_seed = 64'h1; prov_crypt = 64'h2;
        @(negedge clk);
        cmd_valid = 1'b0; prov_valid = 1'b0;
        rsp_seen = 0; ok = 0;
        for (int i = 0; i < 60; i++) begin
            if (rsp_valid) begin rsp_seen++; ok = rsp_ok; end
            @(negedge clk);
        end
        m_ci = f2(m_gc, c1, 64'h0); m_sk = c1 ^ m_gc; m_auth = 1; m_enc = 0;
        check("R9 single response", 64'(rsp_seen), 1);
        check("R9 response ok", 64'(ok), 1);
        check_state("R9 after ignored strobes");

        // R8: lockout on the ninth failure
        while (m_cnt <= 8) begin
            c1 = f2(m_gc, m_ci, 64'h77);
            run_cmd(1'b0, 64'h77, ~c1, ok, err);
            m_cnt++; m_auth = 0; m_enc = 0;
            check("R7 wrong challenge err", 64'(err), 1);
            check("R8 lock threshold", 64'(locked), 64'(m_cnt > 8));
        end
        check_state("R8 after lock");

        // R8: locked verify answered next cycle, no compute
        c1 = f2(m_gc, m_ci, 64'h5);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_q0 = 64'h5; cmd_q1 = c1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R8 immediate rsp_valid", 64'(rsp_valid), 1);
        check("R8 immediate rsp_err", 64'(rsp_err), 1);
        check("R8 not busy", 64'(busy), 0);
        @(negedge clk);
        // R2: provisioning ignored while locked
        prov_valid = 1'b1; prov_seed = 64'h0; prov_crypt = 64'hABCD;
        @(negedge clk);
        prov_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 prov ignored when locked", crypt_out, m_ci);
        check("R8 still locked", 64'(locked), 1);
        check("R8 flags clear", 64'({auth_mode, enc_mode}), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule